// File: doc/BRIEF.md
# I2C Controller Interrupt Status Block

This block collects the event pulses of an I2C transfer engine into a set of sticky status bits, filters them through a per-bit mask and drives one level-sensitive interrupt line. Software reads the status word, clears the bits it has handled by writing ones back to the same word, and changes the mask through two write-only ports: one that unmasks the bits written as one and one that masks them. Because each of these two ports only touches the bits written as one, two agents can adjust their own interrupts without a read-modify-write race.

The data event is not taken from the event inputs. The block makes it from the fill level of the transfer FIFO. It fires once each time the level climbs from below the threshold to the threshold or above. The threshold is two below the FIFO depth, so it is 14 for a 16-entry FIFO.

The register port is a plain word-indexed interface. Writes take effect at the rising clock edge. Read data is combinational from the current register contents, so a read has no side effect.

Top module: `irq_status_top`

## Requirements
- R1: The status and mask words are 10 bits wide with a fixed bit layout. Bit 0 is complete, bit 1 is data, bit 2 is NACK, bit 3 is timeout, bit 4 is slave ready, bit 5 is RX overflow, bit 6 is TX overflow, bit 7 is RX underflow and bit 9 is arbitration lost. Bit 8 is reserved: it reads as 0 in both words and ignores events and writes. The event input at bit 1 is ignored.
- R2: An event pulse on `evtIn` sets the matching status bit at the next rising edge, whether that bit is masked or not. The bit then stays set until it is cleared.
- R3: A write to word 0 (status) clears every status bit whose write-data bit is 1 and leaves the other bits unchanged.
- R4: If an event and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R5: After reset, the status word is 0x000, the mask word is 0x2FF (every implemented bit masked) and `irqOut` is 0. The mask word is read at word 1, where a mask bit of 1 means the interrupt is disabled.
- R6: A write to word 2 (unmask) clears the mask bits whose write-data bit is 1. Bits written as 0 keep their value. Word 2 reads as 0.
- R7: A write to word 3 (mask) sets the mask bits whose write-data bit is 1. Bits written as 0 keep their value. Word 3 reads as 0.
- R8: `irqOut` is high exactly when some status bit is set while its mask bit is 0. It follows the register contents without added delay.
- R9: Status bit 1 is set at the rising edge that ends the first cycle in which `fifoLevel` is 14 or more, after a cycle in which it was below 14. A level that stays at or above 14 does not set the bit again.
- R10: Writes to word 1 and to words 4 to 7 change no state. Words 4 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | Register word index |
| regWrEn | input | 1 | Write strobe for the addressed word |
| regWrData | input | 10 | Write data |
| regRdData | output | 10 | Read data of the addressed word |
| evtIn | input | 10 | Event pulses from the transfer engine, laid out as in R1 |
| fifoLevel | input | 5 | Current fill level of the transfer FIFO |
| irqOut | output | 1 | Interrupt request |

## Verification
The bound checker checks these rules on every cycle:
- the write-one-to-clear and event-priority rules;
- the set and clear behaviour of the unmask and mask ports;
- the reserved bit;
- the match between the interrupt line and the unmasked status bits;
- the FIFO threshold crossing;
- the immunity of the mask word to writes at other word indices.

Some behaviour can only be shown by the bench's scenarios. These are:
- the reset values;
- the read-back of the write-only words as zero;
- the fact that a level held above threshold does not fire again;
- whole sequences in which masking, clearing and re-arming interleave.

// File: rtl/irq_status_pkg.sv
`timescale 1ns/1ps
package irq_status_pkg;
  localparam int EVT_W  = 10;
  localparam int ADDR_W = 3;

  // bit positions (R1)
  localparam int BIT_DONE  = 0;
  localparam int BIT_DATA  = 1;
  localparam int BIT_NACK  = 2;
  localparam int BIT_TMO   = 3;
  localparam int BIT_SRDY  = 4;
  localparam int BIT_RXOVF = 5;
  localparam int BIT_TXOVF = 6;
  localparam int BIT_RXUNF = 7;
  localparam int BIT_RSVD  = 8;
  localparam int BIT_ARB   = 9;

  localparam logic [EVT_W-1:0] IMPL_MASK = ~(EVT_W'(1) << BIT_RSVD);
  localparam logic [EVT_W-1:0] DATA_ONE  = EVT_W'(1) << BIT_DATA;

  // word indices
  localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_UNMK = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_SETM = 3'd3;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_STAT = 2'd1,
    RD_MASK = 2'd2
  } rdSel_e;

  typedef struct packed {
    logic clrStat;
    logic unmask;
    logic setMask;
  } regStrobe_t;
endpackage

// File: rtl/irq_reg_ctrl.sv
`timescale 1ns/1ps
module irq_reg_ctrl
  import irq_status_pkg::*;
(
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        strobe,
  output rdSel_e            rdSel
);
  always_comb begin
    strobe = '0;
    if (regWrEn) begin
      unique case (regAddr)
        ADDR_STAT: strobe.clrStat = 1'b1;   // R3
        ADDR_UNMK: strobe.unmask  = 1'b1;   // R6
        ADDR_SETM: strobe.setMask = 1'b1;   // R7
        default:   strobe = '0;             // R10
      endcase
    end
  end

  always_comb begin
    unique case (regAddr)
      ADDR_STAT: rdSel = RD_STAT;
      ADDR_MASK: rdSel = RD_MASK;
      default:   rdSel = RD_NONE;
    endcase
  end
endmodule

// File: rtl/irq_fifo_thresh.sv
`timescale 1ns/1ps
module irq_fifo_thresh #(
  parameter int FIFO_DEPTH = 16,
  parameter int THR_GAP    = 2,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LVL_W-1:0] fifoLevel,
  output logic             dataEvt
);
  localparam logic [LVL_W-1:0] THR = LVL_W'(FIFO_DEPTH - THR_GAP);

  logic atOrAbove;
  logic wasAbove;

  assign atOrAbove = (fifoLevel >= THR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wasAbove <= 1'b0;
    else       wasAbove <= atOrAbove;
  end

  // R9: one pulse per upward crossing
  assign dataEvt = atOrAbove && !wasAbove;
endmodule

// File: rtl/irq_reg_datapath.sv
`timescale 1ns/1ps
module irq_reg_datapath
  import irq_status_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       strobe,
  input  rdSel_e           rdSel,
  input  logic [EVT_W-1:0] wrData,
  input  logic [EVT_W-1:0] evtSet,
  output logic [EVT_W-1:0] statusVec,
  output logic [EVT_W-1:0] maskVec,
  output logic [EVT_W-1:0] rdData,
  output logic             irqOut
);
  for (genvar i = 0; i < EVT_W; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_live
      logic stQ;
      logic mkQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stQ <= 1'b0;                                  // R5
          mkQ <= 1'b1;
        end else begin
          if (evtSet[i])                        stQ <= 1'b1;  // R2, R4
          else if (strobe.clrStat && wrData[i]) stQ <= 1'b0;  // R3
          if (strobe.setMask && wrData[i])      mkQ <= 1'b1;  // R7
          else if (strobe.unmask && wrData[i])  mkQ <= 1'b0;  // R6
        end
      end
      assign statusVec[i] = stQ;
      assign maskVec[i]   = mkQ;
    end else begin : g_rsvd
      assign statusVec[i] = 1'b0;                       // R1
      assign maskVec[i]   = 1'b0;
    end
  end

  always_comb begin
    unique case (rdSel)
      RD_STAT: rdData = statusVec;
      RD_MASK: rdData = maskVec;
      default: rdData = '0;
    endcase
  end

  assign irqOut = |(statusVec & ~maskVec);              // R8
endmodule

// File: rtl/irq_status_top.sv
`timescale 1ns/1ps
module irq_status_top
  import irq_status_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int THR_GAP    = 2,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [EVT_W-1:0]  regWrData,
  output logic [EVT_W-1:0]  regRdData,
  input  logic [EVT_W-1:0]  evtIn,
  input  logic [LVL_W-1:0]  fifoLevel,
  output logic              irqOut
);
  regStrobe_t       strobe;
  rdSel_e           rdSel;
  logic             dataEvt;
  logic [EVT_W-1:0] evtSet;
  logic [EVT_W-1:0] statusVec;
  logic [EVT_W-1:0] maskVec;

  // R1: external data bit and reserved bit dropped, data comes from threshold
  assign evtSet = (evtIn & IMPL_MASK & ~DATA_ONE) | (dataEvt ? DATA_ONE : '0);

  irq_reg_ctrl u_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobe  (strobe),
    .rdSel   (rdSel)
  );

  irq_fifo_thresh #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .THR_GAP    (THR_GAP),
    .LVL_W      (LVL_W)
  ) u_thresh (
    .clk       (clk),
    .rstN      (rstN),
    .fifoLevel (fifoLevel),
    .dataEvt   (dataEvt)
  );

  irq_reg_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .rdSel     (rdSel),
    .wrData    (regWrData),
    .evtSet    (evtSet),
    .statusVec (statusVec),
    .maskVec   (maskVec),
    .rdData    (regRdData),
    .irqOut    (irqOut)
  );
endmodule

// File: rtl/irq_status_chk.sv
`timescale 1ns/1ps
module irq_status_chk
  import irq_status_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int THR_GAP    = 2,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [EVT_W-1:0]  regWrData,
  input logic [LVL_W-1:0]  fifoLevel,
  input logic [EVT_W-1:0]  evtSet,
  input logic [EVT_W-1:0]  statusVec,
  input logic [EVT_W-1:0]  maskVec,
  input logic              irqOut
);
  localparam logic [LVL_W-1:0] THR = LVL_W'(FIFO_DEPTH - THR_GAP);

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    !statusVec[BIT_RSVD] && !maskVec[BIT_RSVD]);

  a_r2_event_sticks: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusVec & $past(evtSet)) == $past(evtSet)));

  a_r3_w1c: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_STAT) |=>
      ((statusVec & $past(regWrData & ~evtSet)) == '0));

  a_r4_event_beats_clear: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_STAT && (regWrData & evtSet) != '0) |=>
      ((statusVec & $past(regWrData & evtSet)) == $past(regWrData & evtSet)));

  a_r6_unmask: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_UNMK) |=> ((maskVec & $past(regWrData)) == '0));

  a_r7_setmask: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_SETM) |=>
      ((maskVec & $past(regWrData) & IMPL_MASK) == ($past(regWrData) & IMPL_MASK)));

  a_r8_irq_level: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == ((statusVec & ~maskVec) != '0));

  a_r9_threshold: assert property (@(posedge clk) disable iff (!rstN)
    (fifoLevel >= THR && $past(fifoLevel) < THR) |=> statusVec[BIT_DATA]);

  a_r10_mask_word_ro: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && (regAddr == ADDR_MASK || regAddr > ADDR_SETM)) |=> $stable(maskVec));
endmodule

bind irq_status_top irq_status_chk #(
  .FIFO_DEPTH (FIFO_DEPTH),
  .THR_GAP    (THR_GAP),
  .LVL_W      (LVL_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .fifoLevel (fifoLevel),
  .evtSet    (evtSet),
  .statusVec (statusVec),
  .maskVec   (maskVec),
  .irqOut    (irqOut)
);

// File: tb/tb_irq_status_top.sv
`timescale 1ns/1ps
module tb_irq_status_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [9:0] regWrData = '0;
  logic [9:0] regRdData;
  logic [9:0] evtIn = '0;
  logic [4:0] fifoLevel = '0;
  logic       irqOut;

  int checkCnt = 0;
  int errCnt   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  irq_status_top dut (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .evtIn     (evtIn),
    .fifoLevel (fifoLevel),
    .irqOut    (irqOut)
  );

  typedef struct packed {
    logic [2:0] addr;
    logic       wr;
    logic [9:0] wdata;
    logic [9:0] evt;
    logic [4:0] lvl;
    logic [9:0] expS;
    logic [9:0] expM;
    logic       expI;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b0, 10'h000, 10'h001, 5'd0,  10'h001, 10'h2FF, 1'b0}, // R2 masked event sticks
    '{3'd2, 1'b1, 10'h001, 10'h000, 5'd0,  10'h001, 10'h2FE, 1'b1}, // R6 unmask bit0
    '{3'd0, 1'b1, 10'h001, 10'h000, 5'd0,  10'h000, 10'h2FE, 1'b0}, // R3 clear
    '{3'd0, 1'b0, 10'h000, 10'h204, 5'd0,  10'h204, 10'h2FE, 1'b0}, // R1 NACK and arb lost
    '{3'd2, 1'b1, 10'h200, 10'h000, 5'd0,  10'h204, 10'h0FE, 1'b1}, // R8
    '{3'd0, 1'b1, 10'h200, 10'h200, 5'd0,  10'h204, 10'h0FE, 1'b1}, // R4 event wins
    '{3'd3, 1'b1, 10'h200, 10'h000, 5'd0,  10'h204, 10'h2FE, 1'b0}, // R7 mask bit9
    '{3'd0, 1'b1, 10'h004, 10'h000, 5'd0,  10'h200, 10'h2FE, 1'b0}, // R3 partial clear
    '{3'd0, 1'b0, 10'h000, 10'h102, 5'd0,  10'h200, 10'h2FE, 1'b0}, // R1 bits 8 and 1 ignored
    '{3'd0, 1'b0, 10'h000, 10'h000, 5'd14, 10'h202, 10'h2FE, 1'b0}, // R9 crossing
    '{3'd2, 1'b1, 10'h002, 10'h000, 5'd14, 10'h202, 10'h2FC, 1'b1}, // R6
    '{3'd0, 1'b1, 10'h002, 10'h000, 5'd15, 10'h200, 10'h2FC, 1'b0}, // R9 no refire
    '{3'd0, 1'b0, 10'h000, 10'h000, 5'd3,  10'h200, 10'h2FC, 1'b0}, // R9 drop below
    '{3'd0, 1'b0, 10'h000, 10'h000, 5'd13, 10'h200, 10'h2FC, 1'b0}, // R9 just under
    '{3'd0, 1'b0, 10'h000, 10'h000, 5'd16, 10'h202, 10'h2FC, 1'b1}, // R9 jump to full
    '{3'd1, 1'b1, 10'h3FF, 10'h000, 5'd16, 10'h202, 10'h2FC, 1'b1}, // R10 mask word read-only
    '{3'd5, 1'b1, 10'h3FF, 10'h000, 5'd16, 10'h202, 10'h2FC, 1'b1}, // R10 unused word
    '{3'd0, 1'b1, 10'h3FF, 10'h000, 5'd16, 10'h000, 10'h2FC, 1'b0}, // R3 clear all
    '{3'd0, 1'b0, 10'h000, 10'h0F8, 5'd16, 10'h0F8, 10'h2FC, 1'b0}, // R2 masked events
    '{3'd2, 1'b1, 10'h180, 10'h000, 5'd16, 10'h0F8, 10'h27C, 1'b1}, // R6 bit8 ignored
    '{3'd3, 1'b1, 10'h3FF, 10'h000, 5'd16, 10'h0F8, 10'h2FF, 1'b0}  // R7 mask all
  };

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    checkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual 0x%03h expected 0x%03h", req, act, exp);
    end
  endtask

  task automatic readWord(input logic [2:0] a, output logic [9:0] d);
    regWrEn = 1'b0;
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checkCnt, errCnt);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errCnt++;
      $display("FAIL watchdog actual hung expected done");
      finishRun();
    end
  end

  initial begin
    logic [9:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R5 reset values
    readWord(3'd0, rd); chk("R5 status at reset", rd, 10'h000);
    readWord(3'd1, rd); chk("R5 mask at reset", rd, 10'h2FF);
    chk("R5 irq at reset", {9'd0, irqOut}, 10'h000);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      regAddr   = VECS[i].addr;
      regWrEn   = VECS[i].wr;
      regWrData = VECS[i].wdata;
      evtIn     = VECS[i].evt;
      fifoLevel = VECS[i].lvl;
      @(posedge clk);
      @(negedge clk);
      evtIn = '0;
      readWord(3'd0, rd); chk($sformatf("vec%0d status R1 R2 R3 R4 R9", i), rd, VECS[i].expS);
      readWord(3'd1, rd); chk($sformatf("vec%0d mask R6 R7 R10", i), rd, VECS[i].expM);
      chk($sformatf("vec%0d irq R8", i), {9'd0, irqOut}, {9'd0, VECS[i].expI});
    end

    // write-only and unused words read as zero
    readWord(3'd2, rd); chk("R6 unmask word reads 0", rd, 10'h000);
    readWord(3'd3, rd); chk("R7 mask word reads 0", rd, 10'h000);
    readWord(3'd6, rd); chk("R10 unused word reads 0", rd, 10'h000);

    // unmask everything, then reset mid-run
    regAddr = 3'd2; regWrEn = 1'b1; regWrData = 10'h3FF;
    @(posedge clk); @(negedge clk);
    chk("R8 irq with all unmasked", {9'd0, irqOut}, 10'h001);
    regWrEn = 1'b0; fifoLevel = '0;
    rstN = 1'b0;
    #1;
    readWord(3'd0, rd); chk("R5 status after reset", rd, 10'h000);
    readWord(3'd1, rd); chk("R5 mask after reset", rd, 10'h2FF);
    chk("R5 irq after reset", {9'd0, irqOut}, 10'h000);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // crossing right after reset
    fifoLevel = 5'd14;
    @(posedge clk); @(negedge clk);
    readWord(3'd0, rd); chk("R9 crossing after reset", rd, 10'h002);

    done = 1'b1;
    finishRun();
  end
endmodule